// File: doc/BRIEF.md
# Three-Bus Register Datapath

This block holds the working registers of a microcoded 32-bit processor and moves words between them over three buses. In each cycle one register, chosen by a 4-bit select code, drives the B bus. A dedicated holding register drives the A bus all the time, with no select. The result that comes back from the shifter on the C bus is written, on the same clock edge, into every register whose bit is set in a write mask. The ALU, the shifter and the control store sit outside the block. The B and A outputs feed the ALU, and the shifter output returns as C-bus data.

Four of the registers face memory. A word-address register forms a byte address by a two-place left shift. A memory data register takes read data and supplies write data. A program counter holds a byte address for instruction fetch. An 8-bit byte buffer takes fetched bytes and can be seen on the B bus either sign-extended or zero-extended. A memory request made in one cycle is presented on the memory strobes during the next cycle. The returned data is captured at the end of that cycle, so it can be used from the start of the cycle after.

Top module: `regdp_core`

## Requirements
- R1: B-select code 0 drives the memory data register, code 1 the program counter, and codes 4 to 8 the general registers G4 to G8, all onto `b_bus_o`.
- R2: B-select codes 9 to 15 drive all zeros onto `b_bus_o`.
- R3: B-select code 2 drives the byte buffer sign-extended: bits 31..8 copy bit 7 (0x93 gives 0xFFFFFF93, 0x6D gives 0x0000006D).
- R4: B-select code 3 drives the byte buffer zero-extended: bits 31..8 are zero (0x93 gives 0x00000093).
- R5: On a clock edge, every register whose `c_en_i` bit is set loads `c_data_i`. The bits are: 0 word address, 1 memory data, 2 program counter, 3..7 G4..G8, 8 holding register. The byte buffer never loads from the C bus.
- R6: `a_bus_o` always shows the holding register (mask bit 8), with no select.
- R7: `mem_addr_o` shows the word-address register shifted left by two while a read or write strobe is high. It shows the program counter while the fetch strobe is high, and zero when no strobe is high.
- R8: A read request sampled at the edge that ends cycle 1 raises `mem_rd_o` for cycle 2. `mem_rdata_i` is captured into the memory data register at the edge that ends cycle 2.
- R9: A fetch request follows the same timing with `mem_fetch_o`. Bits 7..0 of `mem_rdata_i` are captured into the byte buffer.
- R10: A write request raises `mem_wr_o` for the next cycle. During that cycle `mem_wdata_o` shows the memory data register.
- R11: If a C-bus write to the memory data register falls on the edge where read data returns, the C-bus value is stored.
- R12: At most one strobe is high at a time. When requests arrive together, write wins over read and read wins over fetch, and the losing requests are dropped.
- R13: While `rst_n_i` is low, all registers and strobes are zero at once. Internal reset is released on the second rising clock edge after `rst_n_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| b_sel_i | input | 4 | B-bus source code |
| c_en_i | input | 9 | C-bus write mask |
| c_data_i | input | 32 | C-bus data from the shifter |
| rd_req_i | input | 1 | Word read request |
| wr_req_i | input | 1 | Word write request |
| fetch_req_i | input | 1 | Byte fetch request |
| a_bus_o | output | 32 | A bus (holding register) |
| b_bus_o | output | 32 | B bus |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_fetch_o | output | 1 | Memory fetch strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The hardest case to reach is the edge where a read's returning data and a C-bus write to the memory data register land together. Only a request made one cycle earlier, followed by a mask with bit 1 in the following cycle, lines the two up. The bench issues the read request, then in the strobe cycle drives distinct values on `mem_rdata_i` and `c_data_i`, and reads the register back through select code 0. The same one-cycle offset is used to show the byte buffer staying still under a full C-bus mask and under a fetch that loses to a read.

// File: rtl/regdp_pkg.sv
package regdp_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int NUM_GP  = 5;
  localparam int SEL_W   = 4;
  localparam int ADDR_SH = 2;

  // B-select codes below the general registers
  localparam int SEL_MDR = 0;
  localparam int SEL_PC  = 1;
  localparam int SEL_BSX = 2;
  localparam int SEL_BZX = 3;
  localparam int SEL_GP0 = 4;

  // C-bus mask bit positions
  localparam int CE_MAR = 0;
  localparam int CE_MDR = 1;
  localparam int CE_PC  = 2;
  localparam int CE_GP0 = 3;
endpackage

// File: rtl/regdp_memctl.sv
module regdp_memctl
  import regdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SH = ADDR_SH
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic          fetch_req_i,
  input  logic [DW-1:0] mar_i,
  input  logic [DW-1:0] pc_i,
  output logic          rd_q_o,
  output logic          wr_q_o,
  output logic          fetch_q_o,
  output logic [DW-1:0] addr_o
);
  logic rd_n, wr_n, fe_n;
  logic rd_q, wr_q, fe_q;

  // write beats read beats fetch
  always_comb begin
    wr_n = wr_req_i;
    rd_n = rd_req_i & ~wr_req_i;
    fe_n = fetch_req_i & ~wr_req_i & ~rd_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      fe_q <= fe_n;
    end
  end

  always_comb begin
    if (rd_q || wr_q)  addr_o = DW'(mar_i << SH);
    else if (fe_q)     addr_o = pc_i;
    else               addr_o = '0;
  end

  assign rd_q_o    = rd_q;
  assign wr_q_o    = wr_q;
  assign fetch_q_o = fe_q;
endmodule

// File: rtl/regdp_regfile.sv
module regdp_regfile
  import regdp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BW  = BYTE_W,
  parameter int NGP = NUM_GP,
  localparam int CW = NGP + 4,
  localparam int HB = CW - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic [CW-1:0]           c_en_i,
  input  logic [DW-1:0]           c_data_i,
  input  logic                    rd_done_i,
  input  logic                    fetch_done_i,
  input  logic [DW-1:0]           rdata_i,
  output logic [DW-1:0]           mar_o,
  output logic [DW-1:0]           mdr_o,
  output logic [DW-1:0]           pc_o,
  output logic [BW-1:0]           mbr_o,
  output logic [NGP-1:0][DW-1:0]  gp_o,
  output logic [DW-1:0]           hold_o
);
  logic [DW-1:0]          mar_q, mar_n, mdr_q, mdr_n, pc_q, pc_n, hold_q, hold_n;
  logic [BW-1:0]          mbr_q, mbr_n;
  logic [NGP-1:0][DW-1:0] gp_q, gp_n;

  always_comb begin
    mar_n  = mar_q;
    mdr_n  = mdr_q;
    pc_n   = pc_q;
    mbr_n  = mbr_q;
    gp_n   = gp_q;
    hold_n = hold_q;
    if (c_en_i[CE_MAR]) mar_n = c_data_i;
    if (c_en_i[CE_MDR])  mdr_n = c_data_i;
    else if (rd_done_i)  mdr_n = rdata_i;
    if (c_en_i[CE_PC])   pc_n = c_data_i;
    if (fetch_done_i)    mbr_n = rdata_i[BW-1:0];
    for (int i = 0; i < NGP; i++) begin
      if (c_en_i[CE_GP0+i]) gp_n[i] = c_data_i;
    end
    if (c_en_i[HB]) hold_n = c_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mar_q  <= '0;
      mdr_q  <= '0;
      pc_q   <= '0;
      mbr_q  <= '0;
      hold_q <= '0;
    end else begin
      mar_q  <= mar_n;
      mdr_q  <= mdr_n;
      pc_q   <= pc_n;
      mbr_q  <= mbr_n;
      hold_q <= hold_n;
    end
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) gp_q[g] <= '0;
      else          gp_q[g] <= gp_n[g];
    end
  end

  assign mar_o  = mar_q;
  assign mdr_o  = mdr_q;
  assign pc_o   = pc_q;
  assign mbr_o  = mbr_q;
  assign gp_o   = gp_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/regdp_bsel.sv
module regdp_bsel
  import regdp_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int BW   = BYTE_W,
  parameter int NGP  = NUM_GP,
  parameter int SELW = SEL_W
) (
  input  logic [SELW-1:0]         sel_i,
  input  logic [DW-1:0]           mdr_i,
  input  logic [DW-1:0]           pc_i,
  input  logic [BW-1:0]           mbr_i,
  input  logic [NGP-1:0][DW-1:0]  gp_i,
  output logic [DW-1:0]           bus_o
);
  always_comb begin
    bus_o = '0;
    if (sel_i == SELW'(SEL_MDR))      bus_o = mdr_i;
    else if (sel_i == SELW'(SEL_PC))  bus_o = pc_i;
    else if (sel_i == SELW'(SEL_BSX)) bus_o = {{(DW-BW){mbr_i[BW-1]}}, mbr_i};
    else if (sel_i == SELW'(SEL_BZX)) bus_o = {{(DW-BW){1'b0}}, mbr_i};
    else begin
      for (int i = 0; i < NGP; i++) begin
        if (sel_i == SELW'(SEL_GP0 + i)) bus_o = gp_i[i];
      end
    end
  end
endmodule

// File: rtl/regdp_core.sv
module regdp_core
  import regdp_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int BW   = BYTE_W,
  parameter int NGP  = NUM_GP,
  parameter int SELW = SEL_W,
  localparam int CW  = NGP + 4
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic [SELW-1:0] b_sel_i,
  input  logic [CW-1:0]   c_en_i,
  input  logic [DW-1:0]   c_data_i,
  input  logic            rd_req_i,
  input  logic            wr_req_i,
  input  logic            fetch_req_i,
  output logic [DW-1:0]   a_bus_o,
  output logic [DW-1:0]   b_bus_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            mem_fetch_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i
);
  logic [1:0]             rst_sync_q;
  logic                   rst_n;
  logic [DW-1:0]          mar_q, mdr_q, pc_q, hold_q;
  logic [BW-1:0]          mbr_q;
  logic [NGP-1:0][DW-1:0] gp_q;

  // assert at once, release after two edges
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  regdp_memctl #(.DW(DW), .SH(ADDR_SH)) u_memctl (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .rd_req_i    (rd_req_i),
    .wr_req_i    (wr_req_i),
    .fetch_req_i (fetch_req_i),
    .mar_i       (mar_q),
    .pc_i        (pc_q),
    .rd_q_o      (mem_rd_o),
    .wr_q_o      (mem_wr_o),
    .fetch_q_o   (mem_fetch_o),
    .addr_o      (mem_addr_o)
  );

  regdp_regfile #(.DW(DW), .BW(BW), .NGP(NGP)) u_regfile (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .c_en_i       (c_en_i),
    .c_data_i     (c_data_i),
    .rd_done_i    (mem_rd_o),
    .fetch_done_i (mem_fetch_o),
    .rdata_i      (mem_rdata_i),
    .mar_o        (mar_q),
    .mdr_o        (mdr_q),
    .pc_o         (pc_q),
    .mbr_o        (mbr_q),
    .gp_o         (gp_q),
    .hold_o       (hold_q)
  );

  regdp_bsel #(.DW(DW), .BW(BW), .NGP(NGP), .SELW(SELW)) u_bsel (
    .sel_i (b_sel_i),
    .mdr_i (mdr_q),
    .pc_i  (pc_q),
    .mbr_i (mbr_q),
    .gp_i  (gp_q),
    .bus_o (b_bus_o)
  );

  assign a_bus_o     = hold_q;
  assign mem_wdata_o = mdr_q;
endmodule

// File: rtl/regdp_chk.sv
module regdp_chk
  import regdp_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int BW   = BYTE_W,
  parameter int NGP  = NUM_GP,
  parameter int SELW = SEL_W,
  localparam int CW  = NGP + 4,
  localparam int HB  = CW - 1
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic [SELW-1:0] b_sel_i,
  input logic [CW-1:0]   c_en_i,
  input logic [DW-1:0]   c_data_i,
  input logic            rd_req_i,
  input logic            wr_req_i,
  input logic [DW-1:0]   a_bus_o,
  input logic [DW-1:0]   b_bus_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            mem_fetch_o,
  input logic [DW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_rdata_i,
  input logic [DW-1:0]   mdr_q,
  input logic [BW-1:0]   mbr_q
);
  AST_HIGH_SEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (b_sel_i >= SELW'(NGP + 4)) |-> (b_bus_o == '0)); // R2
  AST_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (b_sel_i == SELW'(SEL_BSX)) |->
      (b_bus_o[DW-1:BW-1] == '0 || b_bus_o[DW-1:BW-1] == '1)); // R3
  AST_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (b_sel_i == SELW'(SEL_BZX)) |-> (b_bus_o[DW-1:BW] == '0)); // R4
  AST_BYTE_NO_CBUS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mem_fetch_o |=> $stable(mbr_q)); // R5
  AST_ABUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    c_en_i[HB] |=> (a_bus_o == $past(c_data_i))); // R6
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> (mem_addr_o[1:0] == 2'b00)); // R7
  AST_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_req_i && !wr_req_i) |=> mem_rd_o); // R8
  AST_RD_RETURN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_rd_o && !c_en_i[CE_MDR]) |=> (mdr_q == $past(mem_rdata_i))); // R8
  AST_WR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_req_i |=> mem_wr_o); // R10
  AST_CBUS_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    c_en_i[CE_MDR] |=> (mdr_q == $past(c_data_i))); // R11
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o, mem_fetch_o})); // R12
endmodule

bind regdp_core regdp_chk #(.DW(DW), .BW(BW), .NGP(NGP), .SELW(SELW)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .b_sel_i     (b_sel_i),
  .c_en_i      (c_en_i),
  .c_data_i    (c_data_i),
  .rd_req_i    (rd_req_i),
  .wr_req_i    (wr_req_i),
  .a_bus_o     (a_bus_o),
  .b_bus_o     (b_bus_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_fetch_o (mem_fetch_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .mdr_q       (mdr_q),
  .mbr_q       (mbr_q)
);

// File: tb/regdp_core_bench.sv
module regdp_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  b_sel;
  logic [8:0]  c_en;
  logic [31:0] c_data;
  logic        rd_req, wr_req, fe_req;
  logic [31:0] a_bus, b_bus, addr, wdata, rdata;
  logic        m_rd, m_wr, m_fe;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  regdp_core u_regdp_core (
    .clk_i (clk), .rst_n_i (rst_n), .b_sel_i (b_sel), .c_en_i (c_en),
    .c_data_i (c_data), .rd_req_i (rd_req), .wr_req_i (wr_req),
    .fetch_req_i (fe_req), .a_bus_o (a_bus), .b_bus_o (b_bus),
    .mem_rd_o (m_rd), .mem_wr_o (m_wr), .mem_fetch_o (m_fe),
    .mem_addr_o (addr), .mem_wdata_o (wdata), .mem_rdata_i (rdata)
  );

  // {c_en, c_data, b_sel, expected b_bus before the edge}
  localparam logic [76:0] VEC [0:13] = '{
    {9'h008, 32'h11111111, 4'd4,  32'h00000000},
    {9'h030, 32'hA5A5A5A5, 4'd4,  32'h11111111},
    {9'h000, 32'h00000000, 4'd5,  32'hA5A5A5A5},
    {9'h000, 32'h00000000, 4'd6,  32'hA5A5A5A5},
    {9'h0C6, 32'hDEADBEEF, 4'd9,  32'h00000000},
    {9'h000, 32'h00000000, 4'd7,  32'hDEADBEEF},
    {9'h000, 32'h00000000, 4'd8,  32'hDEADBEEF},
    {9'h000, 32'h00000000, 4'd0,  32'hDEADBEEF},
    {9'h000, 32'h00000000, 4'd1,  32'hDEADBEEF},
    {9'h000, 32'h00000000, 4'd15, 32'h00000000},
    {9'h000, 32'h00000000, 4'd2,  32'h00000000},
    {9'h1FF, 32'h12345678, 4'd3,  32'h00000000},
    {9'h000, 32'h00000000, 4'd2,  32'h00000000},
    {9'h000, 32'h00000000, 4'd4,  32'h12345678}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] en, input logic [31:0] cd, input logic [3:0] sel,
                       input logic rd, input logic wr, input logic fe, input logic [31:0] rdt);
    @(negedge clk);
    c_en = en; c_data = cd; b_sel = sel;
    rd_req = rd; wr_req = wr; fe_req = fe; rdata = rdt;
    #5;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; b_sel = '0; c_en = '0; c_data = '0;
    rd_req = 0; wr_req = 0; fe_req = 0; rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 reset b_bus", b_bus, 32'h0);
    chk("R13 reset a_bus", a_bus, 32'h0);
    chk("R13 reset strobes", {29'd0, m_rd, m_wr, m_fe}, 32'h0);
    chk("R7 idle address", addr, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 14; i++) begin
      drive(VEC[i][76:68], VEC[i][67:36], VEC[i][35:32], 0, 0, 0, 32'h0);
      chk($sformatf("R1 R2 R5 vector %0d", i), b_bus, VEC[i][31:0]);
    end
    chk("R6 a_bus after full mask", a_bus, 32'h12345678);

    // R6: holding register
    drive(9'h100, 32'hCAFE0001, 4'd0, 0, 0, 0, 32'h0);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h0);
    chk("R6 a_bus", a_bus, 32'hCAFE0001);

    // R8 read with R7 address shift
    drive(9'h001, 32'hC0000005, 4'd0, 1, 0, 0, 32'h0);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h87654321);
    chk("R8 rd strobe", {31'd0, m_rd}, 32'h1);
    chk("R7 word address shift", addr, 32'h00000014);
    chk("R8 data not yet in cycle 2", b_bus, 32'h12345678);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h0);
    chk("R8 data in cycle 3", b_bus, 32'h87654321);
    chk("R8 strobe dropped", {31'd0, m_rd}, 32'h0);

    // R9 fetch of a negative byte
    drive(9'h004, 32'h00000103, 4'd3, 0, 0, 1, 32'h0);
    drive(9'h000, 32'h0, 4'd3, 0, 0, 0, 32'hFFFFFF93);
    chk("R9 fetch strobe", {31'd0, m_fe}, 32'h1);
    chk("R7 fetch address", addr, 32'h00000103);
    chk("R9 byte not yet", b_bus, 32'h0);
    drive(9'h000, 32'h0, 4'd2, 0, 0, 0, 32'h0);
    chk("R3 sign extend 0x93", b_bus, 32'hFFFFFF93);
    b_sel = 4'd3; #1;
    chk("R4 zero extend 0x93", b_bus, 32'h00000093);

    // R10 write
    drive(9'h002, 32'h5A5A0000, 4'd0, 0, 1, 0, 32'h0);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h0);
    chk("R10 wr strobe", {31'd0, m_wr}, 32'h1);
    chk("R10 write data", wdata, 32'h5A5A0000);
    chk("R7 write address", addr, 32'h00000014);

    // R11 C bus beats read return
    drive(9'h000, 32'h0, 4'd0, 1, 0, 0, 32'h0);
    drive(9'h002, 32'h0BADF00D, 4'd0, 0, 0, 0, 32'h11112222);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h0);
    chk("R11 C bus priority", b_bus, 32'h0BADF00D);

    // R12 read beats fetch, fetch dropped
    drive(9'h000, 32'h0, 4'd0, 1, 0, 1, 32'h0);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h0000006D);
    chk("R12 read wins strobes", {29'd0, m_rd, m_wr, m_fe}, 32'h4);
    chk("R12 read address", addr, 32'h00000014);
    drive(9'h000, 32'h0, 4'd2, 0, 0, 0, 32'h0);
    chk("R12 dropped fetch leaves byte", b_bus, 32'hFFFFFF93);

    // R12 write beats read
    drive(9'h000, 32'h0, 4'd0, 1, 1, 0, 32'h0);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'hFFFFFFFF);
    chk("R12 write wins strobes", {29'd0, m_rd, m_wr, m_fe}, 32'h2);
    drive(9'h000, 32'h0, 4'd0, 0, 0, 0, 32'h0);
    chk("R12 dropped read leaves data", b_bus, 32'h0000006D);

    // R3 R4 with a positive byte
    drive(9'h000, 32'h0, 4'd2, 0, 0, 1, 32'h0);
    drive(9'h000, 32'h0, 4'd2, 0, 0, 0, 32'hABCDEF6D);
    drive(9'h000, 32'h0, 4'd2, 0, 0, 0, 32'h0);
    chk("R3 sign extend 0x6D", b_bus, 32'h0000006D);
    b_sel = 4'd3; #1;
    chk("R4 zero extend 0x6D", b_bus, 32'h0000006D);

    // R13 asynchronous reset mid-run
    drive(9'h000, 32'h0, 4'd6, 0, 0, 0, 32'h0);
    rst_n = 1'b0; #1;
    chk("R13 async clear", b_bus, 32'h0);
    chk("R13 async clear a_bus", a_bus, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    drive(9'h008, 32'h77777777, 4'd4, 0, 0, 0, 32'h0);
    drive(9'h000, 32'h0, 4'd4, 0, 0, 0, 32'h0);
    chk("R13 held in reset one edge", b_bus, 32'h0);
    drive(9'h008, 32'h77777777, 4'd4, 0, 0, 0, 32'h0);
    drive(9'h000, 32'h0, 4'd4, 0, 0, 0, 32'h0);
    chk("R13 released after two edges", b_bus, 32'h77777777);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule